// File: doc/BRIEF.md
# Serial Flash Boot Reader with I/O-Mode Recovery

This block fetches a boot image from an external serial flash right after reset. An earlier application may have left the flash in a two-line or four-line transfer mode, for example after a watchdog reset where the flash kept its power. The block therefore first brings the flash back to plain one-line operation. It does this with a chain of short recovery frames. All four data lines are held high during these frames, so every frame carries an all-ones command whatever width the flash samples. After that the block issues the one-line read command that every serial flash accepts.

A single start pulse latches a start address, a byte length and a clock divider setting. The block then runs the whole sequence with no further input. It raises `busy` while it works. Received bytes leave through a valid/ready byte port. The serial clock pauses between bytes whenever the consumer holds off, and chip select stays low during the pause. A one-cycle `done` pulse marks the end of the run.

Top module: `flash_boot_reader`

## Requirements
- R1: After reset and whenever idle, `cs_n` is 1, `sclk` is 0, `sio_oe` is 4'b0000, `busy` is 0 and `out_valid` is 0.
- R2: A `start` pulse while idle raises `busy` in the next cycle with `cs_n` still high. A `start` pulse while busy is ignored: the run keeps its original address and length and finishes with a single `done`.
- R3: Four recovery frames come first. Each frame is framed by `cs_n` low and carries exactly 2, 4, 8 and then 16 rising `sclk` edges, in that order. `sclk` is never high while `cs_n` is high.
- R4: During the recovery frames all four `sio_oe` bits are 1 and all four `sio_out` bits are 1.
- R5: Chip select stays high for exactly 8 half-periods (four `sclk` periods) between frames. It falls exactly one half-period before the first rising `sclk` edge of a frame.
- R6: The read frame shifts out command byte 0x03 and then the 24-bit start address, MSB first, on `sio_out[0]`. The bit changes only on falling `sclk`. Throughout the read frame `sio_oe` is 4'b0001.
- R7: Read data is sampled from `sio_in[1]` on each rising `sclk` after the 32 command/address clocks, MSB first. Each group of 8 clocks is delivered as one byte on `out_data` with `out_valid`.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold. Before the next byte starts, `sclk` stays low and `cs_n` stays low until the byte is taken.
- R9: The read frame has exactly 32 + 8×length rising edges, after which `cs_n` rises. Once the last byte is taken, `done` pulses for one cycle and `busy` falls in that same cycle.
- R10: With length 0, only the four recovery frames run, no read frame is issued, and `done` still pulses.
- R11: One half-period of `sclk` lasts `clk_div`+1 system cycles, with `clk_div` latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a boot read (one-cycle pulse) |
| start_addr | input | 24 | First flash byte address |
| byte_len | input | 16 | Number of bytes to read |
| clk_div | input | 8 | Half-period of sclk minus one, in system cycles |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| sio_out | output | 4 | Data line output values |
| sio_oe | output | 4 | Data line output enables |
| sio_in | input | 4 | Data line input values; bit 1 carries read data |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | Received byte available |
| out_ready | input | 1 | Consumer accepts the byte |

## Verification
The hardest situation to reach is a consumer stall that lands exactly on a byte boundary inside the read frame. At that point the clock must freeze low with chip select still asserted. To reach it, the stimulus drives `out_ready` at random with low acceptance rates across several divider settings, so many byte boundaries meet a held-off consumer. A second hard case is a start pulse that arrives mid-run. One directed run injects a start with a different address during the preamble. It then confirms from the captured command bits and the frame count that the run went on unchanged. A pin-level flash model counts clocks per frame and supplies read data, so the recovery chain and the read are judged only from the pins.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_FIN
  } fbr_state_e;

  localparam int unsigned NUM_PRE    = 4;
  localparam int unsigned GAP_HALVES = 8;
  localparam logic [7:0]  READ_CMD   = 8'h03;

  // recovery frame clock counts: 2, 4, 8, 16
  function automatic int pre_clocks(input int idx);
    return 2 << idx;
  endfunction

endpackage

// File: rtl/fbr_tick.sv
module fbr_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en || tick)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fbr_rxbyte.sv
module fbr_rxbyte (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample,
  input  logic       din,
  input  logic       push,
  output logic [7:0] data,
  output logic       valid,
  input  logic       ready
);
  logic [7:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      data  <= '0;
      valid <= 1'b0;
    end else begin
      if (sample) sh <= {sh[6:0], din};
      if (push) begin
        data  <= sh;
        valid <= 1'b1;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_boot_reader.sv
module flash_boot_reader
  import fbr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  byte_len,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              cs_n,
  output logic [3:0]        sio_out,
  output logic [3:0]        sio_oe,
  input  logic [3:0]        sio_in,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int unsigned CMD_BITS = 8 + ADDR_W;
  localparam int unsigned CNT_W    = $clog2(CMD_BITS + 1);
  localparam int unsigned IDX_W    = $clog2(NUM_PRE);
  localparam int unsigned GAP_W    = $clog2(GAP_HALVES);

  function automatic logic [CMD_BITS-1:0] read_word(input logic [ADDR_W-1:0] a);
    return {READ_CMD, a};
  endfunction

  fbr_state_e          st;
  logic [IDX_W-1:0]    idx;
  logic [CNT_W-1:0]    clk_cnt;
  logic [GAP_W-1:0]    gap_cnt;
  logic [2:0]          bit_cnt;
  logic [LEN_W-1:0]    bytes_left, len_r;
  logic [ADDR_W-1:0]   addr_r;
  logic [DIV_W-1:0]    div_r;
  logic [CMD_BITS-1:0] tx_sh;
  logic                in_data, read_ph;

  // named internal events
  logic tick, stall, rise_ev, fall_ev, push;
  logic unused_pins;

  assign unused_pins = ^{sio_in[3:2], sio_in[0]};
  assign busy    = (st != ST_IDLE);
  assign stall   = (st == ST_LOW) && in_data && (bit_cnt == 3'd0) && out_valid && !out_ready;
  assign rise_ev = tick && ((st == ST_SETUP) || ((st == ST_LOW) && !stall));
  assign fall_ev = tick && (st == ST_HIGH);
  assign push    = fall_ev && in_data && (bit_cnt == 3'd7);

  assign sio_out = read_ph ? {3'b111, tx_sh[CMD_BITS-1]} : 4'hF;
  assign sio_oe  = !busy ? 4'h0 : (read_ph ? 4'b0001 : 4'hF);

  fbr_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (busy && (st != ST_FIN)),
    .div  (div_r),
    .tick (tick)
  );

  fbr_rxbyte u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .sample(rise_ev && in_data),
    .din   (sio_in[1]),
    .push  (push),
    .data  (out_data),
    .valid (out_valid),
    .ready (out_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cs_n <= 1'b1; sclk <= 1'b0; idx <= '0; clk_cnt <= '0;
      gap_cnt <= '0; bit_cnt <= '0; bytes_left <= '0; len_r <= '0;
      addr_r <= '0; div_r <= '0; tx_sh <= '0; in_data <= 1'b0;
      read_ph <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rise_ev) begin
        sclk <= 1'b1;
        st   <= ST_HIGH;
        if (!in_data) clk_cnt <= clk_cnt + 1'b1;
      end
      unique case (st)
        ST_IDLE: if (start) begin
          addr_r  <= start_addr;
          len_r   <= byte_len;
          div_r   <= clk_div;
          idx     <= '0;
          gap_cnt <= '0;
          read_ph <= 1'b0;
          st      <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (int'(gap_cnt) == GAP_HALVES - 1) begin
            gap_cnt <= '0;
            if (read_ph && (len_r == '0)) begin
              st <= ST_FIN;
            end else begin
              cs_n       <= 1'b0;
              clk_cnt    <= '0;
              in_data    <= 1'b0;
              bit_cnt    <= '0;
              bytes_left <= len_r;
              st         <= ST_SETUP;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_HIGH: if (tick) begin
          sclk <= 1'b0;
          st   <= ST_LOW;
          if (!read_ph) begin
            if (int'(clk_cnt) == pre_clocks(int'(idx))) begin
              cs_n <= 1'b1;
              st   <= ST_GAP;
              if (int'(idx) == NUM_PRE - 1) begin
                read_ph <= 1'b1;
                tx_sh   <= read_word(addr_r);
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end else if (!in_data) begin
            tx_sh <= {tx_sh[CMD_BITS-2:0], 1'b0};
            if (int'(clk_cnt) == CMD_BITS) in_data <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 3'd7) begin
              bytes_left <= bytes_left - 1'b1;
              if (bytes_left == 1) begin
                cs_n <= 1'b1;
                st   <= ST_FIN;
              end
            end
          end
        end
        ST_FIN: if (!out_valid) begin
          done    <= 1'b1;
          read_ph <= 1'b0;
          st      <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fbr_checker.sv
module fbr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] sio_out,
  input logic [3:0] sio_oe,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       stall
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sio_oe == 4'h0) && cs_n && !sclk);

  assert_run_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_clock_only_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_lines_high_in_recovery_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe == 4'hF) |-> (sio_out == 4'hF));

  assert_single_line_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sio_oe != 4'hF) |-> (sio_oe == 4'b0001));

  assert_hold_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_freeze_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!sclk && !cs_n));

  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind flash_boot_reader fbr_checker u_fbr_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .sio_out  (sio_out),
  .sio_oe   (sio_oe),
  .out_data (out_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .stall    (stall)
);

// File: tb/tb_flash_boot_reader.sv
module tb_flash_boot_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic [15:0] byte_len = '0;
  logic [7:0]  clk_div = '0;
  logic        busy, done, sclk, cs_n, out_valid;
  logic [3:0]  sio_out, sio_oe;
  logic [3:0]  fl_in = 4'h0;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  flash_boot_reader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_len(byte_len), .clk_div(clk_div), .busy(busy), .done(done),
    .sclk(sclk), .cs_n(cs_n), .sio_out(sio_out), .sio_oe(sio_oe),
    .sio_in(fl_in), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] flash_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  // pin-level monitor and flash model
  int          cyc = 0, hp = 1, frame_no = 0;
  int          frame_clk [0:8];
  longint      fall_st = 0, csr_st = 0, lr_st = 0;
  bit          first_rise = 0, prev_cs = 1, prev_sclk = 0;
  int          gap_err = 0, setup_err = 0, per_err = 0, oe_err = 0, stab_err = 0;
  logic [31:0] cmd_cap = '0;
  logic [23:0] cur_addr = '0;
  logic [7:0]  rx [0:63];
  int          rx_n = 0, rmode = 0;
  bit          pv = 0, pr = 0;
  logic [7:0]  pd = '0;

  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      frame_no++;
      if (frame_no <= 8) frame_clk[frame_no] = 0;
      if (frame_no > 1 && (cyc - csr_st) != 8 * hp) gap_err++;
      fall_st = cyc;
      first_rise = 1;
    end
    if (!prev_cs && cs_n) csr_st = cyc;
    if (!prev_sclk && sclk && frame_no >= 1 && frame_no <= 8) begin
      frame_clk[frame_no]++;
      if (first_rise) begin
        if ((cyc - fall_st) != hp) setup_err++;
      end else if (frame_no <= 4 && (cyc - lr_st) != 2 * hp) begin
        per_err++;
      end
      first_rise = 0;
      lr_st = cyc;
      if (frame_no <= 4) begin
        if (sio_oe != 4'hF || sio_out != 4'hF) oe_err++;
      end else begin
        if (sio_oe != 4'b0001) oe_err++;
        if (frame_clk[frame_no] <= 32) cmd_cap = {cmd_cap[30:0], sio_out[0]};
      end
    end
    if (prev_sclk && !sclk && frame_no == 5 && frame_clk[5] >= 32) begin
      automatic int k = frame_clk[5] - 32;
      automatic logic [7:0] b = flash_byte(cur_addr + 24'(k / 8));
      fl_in[1] = b[7 - (k % 8)];
    end
    // consumer
    if (pv && pr) begin
      if (rx_n < 64) rx[rx_n] = pd;
      rx_n++;
    end else if (pv) begin
      if (!out_valid || out_data != pd) stab_err++;
    end
    pv = out_valid;
    pd = out_data;
    case (rmode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 4) == 0;
      default: out_ready = ($urandom % 8) == 0;
    endcase
    pr = out_ready;
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic run_boot(input logic [7:0] dv, input logic [23:0] ad,
                          input logic [15:0] ln, input int rm, input bit poke);
    int waitc, dones;
    @(negedge clk);
    frame_no = 0; gap_err = 0; setup_err = 0; per_err = 0; oe_err = 0;
    stab_err = 0; rx_n = 0; cmd_cap = '0;
    hp = int'(dv) + 1; cur_addr = ad; rmode = rm;
    clk_div = dv; start_addr = ad; byte_len = ln; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && cs_n, "R2", "busy after start with cs high", {busy, cs_n}, 2'b11);
    waitc = 0; dones = 0;
    while (!done && waitc < 40000) begin
      @(negedge clk);
      waitc++;
      if (poke && waitc == 60) begin
        start_addr = ad ^ 24'h5A5A5A; byte_len = ln + 3; clk_div = dv + 2; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    chk(done, "R9", "done seen", done, 1);
    chk(!busy, "R9", "busy low with done", busy, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk(dones == 0, "R2", "no second done", dones, 0);
    chk(sio_oe == 4'h0 && cs_n && !sclk, "R1", "idle pins after run", {sio_oe, cs_n, sclk}, 6'b000010);
    chk(frame_no == (ln == 0 ? 4 : 5), (ln == 0) ? "R10" : "R9", "frame count", frame_no, (ln == 0 ? 4 : 5));
    for (int f = 1; f <= 4; f++)
      chk(frame_no >= f && frame_clk[f] == (2 << (f - 1)), "R3", "recovery frame clocks",
          frame_clk[f], 2 << (f - 1));
    chk(oe_err == 0, "R4", "line drive errors", oe_err, 0);
    chk(gap_err == 0, "R5", "cs high gap errors", gap_err, 0);
    chk(setup_err == 0, "R5", "cs setup errors", setup_err, 0);
    chk(per_err == 0, "R11", "sclk period errors", per_err, 0);
    if (ln != 0) begin
      chk(frame_clk[5] == 32 + 8 * int'(ln), "R9", "read frame clocks", frame_clk[5], 32 + 8 * int'(ln));
      chk(cmd_cap == {8'h03, ad}, "R6", "command and address", cmd_cap, {8'h03, ad});
    end
    chk(rx_n == int'(ln), "R7", "byte count", rx_n, ln);
    for (int i = 0; i < int'(ln) && i < rx_n && i < 64; i++)
      chk(rx[i] == flash_byte(ad + 24'(i)), "R7", "read byte", rx[i], flash_byte(ad + 24'(i)));
    chk(stab_err == 0, "R8", "byte hold errors", stab_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1", "reset cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
    chk(sio_oe == 4'h0, "R1", "reset oe", sio_oe, 0);
    chk(!busy && !out_valid, "R1", "reset busy/valid", {busy, out_valid}, 0);

    run_boot(8'd0, 24'h000000, 16'd1, 0, 1'b0);
    run_boot(8'd2, 24'hABCDEF, 16'd0, 0, 1'b0);   // R10 zero length
    run_boot(8'd1, 24'hFFFFFE, 16'd3, 1, 1'b0);   // address wrap, backpressure
    run_boot(8'd0, 24'h123456, 16'd4, 2, 1'b0);   // R8 heavy stalls at div 0
    run_boot(8'd1, 24'h00F00F, 16'd2, 0, 1'b1);   // R2 start while busy
    for (int n = 0; n < 6; n++)
      run_boot(8'($urandom % 4), 24'($urandom), 16'(1 + $urandom % 8), int'($urandom % 3), 1'b0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule